// File: doc/BRIEF.md
# Inquiry Hop Phase Input Generator

This block forms the 5-bit phase input that a frequency-hopping selection kernel consumes during device discovery. It samples a 17-bit free-running native slot clock and a 5-bit reply counter, then produces the phase value X together with the two kernel control bits Y1 and Y2. Which formula applies depends on the role the device is playing in discovery.

In scan and reply roles, X is the top five clock bits plus the reply counter, modulo 32. The inquiring role uses a different chain. It gathers four scattered low clock bits and subtracts the top clock field modulo 16. It then adds the top field back modulo 32, and finally adds a train offset. Clock bit 4 selects that offset: 24 when it is set, 8 when it is clear. A reply role can also look one slot ahead, computing X as if the clock had already advanced by one. This lets the next slot's frequency be predicted.

The inputs are sampled on a `strobe` pulse. One clock later the results appear on registered outputs, with `out_valid` raised for that cycle. The reply counter and the slot clock are kept outside the block.

Top module: `inq_hop_xgen`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `out_valid`, `x_out`, `y1_out` and `y2_out` are all 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `strobe` high. Without a strobe, `x_out`, `y1_out` and `y2_out` keep their previous values.
- R3: With mode code 2'b00 (scan), `x_out` = (native_clk[16:12] + resp_cnt) mod 32, and both `y1_out` and `y2_out` are 0.
- R4: With mode code 2'b01 (inquiry), `x_out` = ((({native_clk[4:2], native_clk[0]} − native_clk[15:12]) mod 16) + native_clk[16:12] + T) mod 32. T is 24 if native_clk[4] is 1 and 8 otherwise.
- R5: With mode code 2'b01, `y1_out` and `y2_out` both equal native_clk[1]. `y2_out` represents a kernel weight of 32.
- R6: With mode code 2'b10 and `next_slot` = 0 (reply), `x_out` follows the R3 formula, and `y1_out` and `y2_out` are both 1.
- R7: With mode code 2'b10 and `next_slot` = 1, `x_out` is computed as in R6 from (native_clk + 1) mod 2^17. A clock of all ones therefore wraps to 0. `y1_out` and `y2_out` are both 1.
- R8: `next_slot` has no effect in mode codes 2'b00, 2'b01 and 2'b11.
- R9: The spare mode code 2'b11 behaves exactly like scan (R3).
- R10: In inquiry mode, `resp_cnt` has no effect on `x_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Sample request for the inputs below |
| mode | input | 2 | Role code: 00 scan, 01 inquiry, 10 reply, 11 spare (as scan) |
| next_slot | input | 1 | In reply role, compute for the following slot |
| native_clk | input | 17 | Native slot clock value |
| resp_cnt | input | 5 | Reply counter |
| x_out | output | 5 | Phase input X for the hop kernel |
| y1_out | output | 1 | Kernel control bit Y1 |
| y2_out | output | 1 | Kernel control bit Y2 (weight 32) |
| out_valid | output | 1 | High for one cycle with each result |

## Verification
The bench applies inquiry clocks in which the gathered low nibble is smaller than the top field. A design that dropped the modulo-16 wrap would then add a stray 16 to X. It also applies clocks with bit 4 both set and clear, which exposes a swapped or fixed train offset. For the look-ahead path it drives a clock of all ones and a clock whose low twelve bits are all ones. A look-ahead that failed to carry into the top field, or failed to wrap, would return the current-slot value. The bench also sets `next_slot` in scan and inquiry modes and varies the counter during inquiry, to catch a design that leaks either input into a role where it should have no effect.

// File: rtl/ihg_pkg.sv
package ihg_pkg;

   // Role codes on the mode input
   typedef enum logic [1:0] {
      ROLE_SCAN  = 2'b00,
      ROLE_INQ   = 2'b01,
      ROLE_REPLY = 2'b10,
      ROLE_SPARE = 2'b11
   } ihg_role_e;

   // Control word produced by the role decoder
   typedef struct packed {
      logic sel_inq;
      logic advance;
      logic y1;
      logic y2;
   } ihg_ctl_t;

endpackage

// File: rtl/ihg_mode_dec.sv
module ihg_mode_dec
   import ihg_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       next_slot,
   input  logic       clk_b1,
   output ihg_ctl_t   ctl
);

   ihg_role_e role;

   always_comb begin
      role = ihg_role_e'(mode);
      ctl  = '0;
      case (role)
         ROLE_INQ: begin
            ctl.sel_inq = 1'b1;
            ctl.y1      = clk_b1;
            ctl.y2      = clk_b1;
         end
         ROLE_REPLY: begin
            ctl.advance = next_slot;
            ctl.y1      = 1'b1;
            ctl.y2      = 1'b1;
         end
         default: begin
            // scan and the spare code: plain sum, control bits low
            ctl = '0;
         end
      endcase
   end

endmodule

// File: rtl/ihg_inq_path.sv
module ihg_inq_path #(
   parameter int X_W     = 5,
   parameter int TRAIN_A = 24,
   parameter int TRAIN_B = 8
) (
   input  logic [X_W-2:0] gather,
   input  logic [X_W-1:0] hi,
   input  logic           train_sel,
   output logic [X_W-1:0] x
);

   localparam int G_W = X_W - 1;

   logic [G_W-1:0] diff;
   logic [X_W-1:0] offset;
   logic [X_W-1:0] partial;

   always_comb begin
      // first step wraps at 2^(X_W-1)
      diff    = gather - hi[G_W-1:0];
      partial = {1'b0, diff} + hi;
      offset  = train_sel ? X_W'(TRAIN_A) : X_W'(TRAIN_B);
      x       = partial + offset;
   end

endmodule

// File: rtl/ihg_reply_path.sv
module ihg_reply_path #(
   parameter int X_W  = 5,
   parameter int LO_W = 12
) (
   input  logic [LO_W-1:0] lo,
   input  logic [X_W-1:0]  hi,
   input  logic [X_W-1:0]  cnt,
   input  logic            advance,
   output logic [X_W-1:0]  x
);

   logic carry;

   always_comb begin
      // +1 on the whole clock only reaches the top field when the low part is all ones
      carry = advance & (&lo);
      x     = hi + cnt + X_W'(carry);
   end

endmodule

// File: rtl/inq_hop_xgen.sv
module inq_hop_xgen
   import ihg_pkg::*;
#(
   parameter int CLK_W   = 17,
   parameter int X_W     = 5,
   parameter int CNT_W   = 5,
   parameter int TRAIN_A = 24,
   parameter int TRAIN_B = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [1:0]       mode,
   input  logic             next_slot,
   input  logic [CLK_W-1:0] native_clk,
   input  logic [CNT_W-1:0] resp_cnt,
   output logic [X_W-1:0]   x_out,
   output logic             y1_out,
   output logic             y2_out,
   output logic             out_valid
);

   localparam int HI_LSB = CLK_W - X_W;
   localparam int G_W    = X_W - 1;

   // elaboration-time parameter checks
   if (X_W < 3) begin : g_bad_xw
      $error("X_W must be at least 3");
   end
   if (CNT_W != X_W) begin : g_bad_cnt
      $error("CNT_W must equal X_W");
   end
   if (HI_LSB < X_W) begin : g_bad_clk
      $error("CLK_W must leave at least X_W low bits");
   end
   if (TRAIN_A >= (1 << X_W) || TRAIN_B >= (1 << X_W)) begin : g_bad_train
      $error("train offsets must fit in X_W bits");
   end

   ihg_ctl_t       ctl;
   logic [G_W-1:0] gather;
   logic [X_W-1:0] hi_field;
   logic [X_W-1:0] x_inq;
   logic [X_W-1:0] x_reply;
   logic [X_W-1:0] x_next;

   assign hi_field = native_clk[HI_LSB +: X_W];
   assign gather   = {native_clk[X_W-1:2], native_clk[0]};

   ihg_mode_dec u_dec (
      .mode      (mode),
      .next_slot (next_slot),
      .clk_b1    (native_clk[1]),
      .ctl       (ctl)
   );

   ihg_inq_path #(
      .X_W     (X_W),
      .TRAIN_A (TRAIN_A),
      .TRAIN_B (TRAIN_B)
   ) u_inq (
      .gather    (gather),
      .hi        (hi_field),
      .train_sel (native_clk[X_W-1]),
      .x         (x_inq)
   );

   ihg_reply_path #(
      .X_W  (X_W),
      .LO_W (HI_LSB)
   ) u_reply (
      .lo      (native_clk[HI_LSB-1:0]),
      .hi      (hi_field),
      .cnt     (resp_cnt),
      .advance (ctl.advance),
      .x       (x_reply)
   );

   assign x_next = ctl.sel_inq ? x_inq : x_reply;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_out     <= '0;
         y1_out    <= 1'b0;
         y2_out    <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= strobe;
         if (strobe) begin
            x_out  <= x_next;
            y1_out <= ctl.y1;
            y2_out <= ctl.y2;
         end
      end
   end

endmodule

// File: rtl/inq_hop_xgen_chk.sv
module inq_hop_xgen_chk #(
   parameter int CLK_W   = 17,
   parameter int X_W     = 5,
   parameter int CNT_W   = 5,
   parameter int TRAIN_A = 24,
   parameter int TRAIN_B = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             strobe,
   input logic [1:0]       mode,
   input logic             next_slot,
   input logic [CLK_W-1:0] native_clk,
   input logic [CNT_W-1:0] resp_cnt,
   input logic [X_W-1:0]   x_out,
   input logic             y1_out,
   input logic             y2_out,
   input logic             out_valid
);

   localparam int HI_LSB = CLK_W - X_W;

   logic [X_W-1:0] plain_sum;
   logic           scan_like;
   assign plain_sum = native_clk[HI_LSB +: X_W] + resp_cnt;
   assign scan_like = (mode == 2'b00) || (mode == 2'b11);

   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> out_valid);                                              // R2
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> !out_valid);                                            // R2
   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> ($stable(x_out) && $stable(y1_out) && $stable(y2_out))); // R2
   AST_SCAN_Y_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && scan_like) |=> (!y1_out && !y2_out));                    // R3
   AST_SCAN_X_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && scan_like) |=> (x_out == $past(plain_sum)));             // R9
   AST_REPLY_Y_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && mode == 2'b10) |=> (y1_out && y2_out));                  // R6
   AST_REPLY_X_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && mode == 2'b10 && !next_slot) |=> (x_out == $past(plain_sum))); // R6
   AST_INQ_Y_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && mode == 2'b01) |=> (y1_out == $past(native_clk[1]) && y2_out == y1_out)); // R5

endmodule

bind inq_hop_xgen inq_hop_xgen_chk #(
   .CLK_W   (CLK_W),
   .X_W     (X_W),
   .CNT_W   (CNT_W),
   .TRAIN_A (TRAIN_A),
   .TRAIN_B (TRAIN_B)
) u_chk (.*);

// File: tb/inq_hop_xgen_tb.sv
module inq_hop_xgen_tb;

   logic        clk_i = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        next_slot = 1'b0;
   logic [16:0] native_clk = '0;
   logic [4:0]  resp_cnt = '0;
   logic [4:0]  x_out;
   logic        y1_out;
   logic        y2_out;
   logic        out_valid;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #4 clk_i = ~clk_i;

   inq_hop_xgen u_dut (
      .clk        (clk_i),
      .rst_n      (rst_n),
      .strobe     (strobe),
      .mode       (mode),
      .next_slot  (next_slot),
      .native_clk (native_clk),
      .resp_cnt   (resp_cnt),
      .x_out      (x_out),
      .y1_out     (y1_out),
      .y2_out     (y2_out),
      .out_valid  (out_valid)
   );

   // stimulus: {mode, next_slot, native_clk, resp_cnt}
   localparam int NV = 16;
   localparam logic [24:0] VEC [NV] = '{
      {2'b00, 1'b0, 17'h00000, 5'd0},
      {2'b00, 1'b0, 17'h1F000, 5'd1},
      {2'b00, 1'b0, 17'h0A5C3, 5'd17},
      {2'b11, 1'b0, 17'h13ABC, 5'd9},
      {2'b01, 1'b0, 17'h00000, 5'd0},
      {2'b01, 1'b0, 17'h1F01D, 5'd4},
      {2'b01, 1'b0, 17'h0C003, 5'd31},
      {2'b01, 1'b0, 17'h1F012, 5'd2},
      {2'b01, 1'b0, 17'h05FFF, 5'd6},
      {2'b01, 1'b0, 17'h1E00E, 5'd11},
      {2'b10, 1'b0, 17'h1F000, 5'd1},
      {2'b10, 1'b0, 17'h08765, 5'd20},
      {2'b10, 1'b1, 17'h00FFF, 5'd0},
      {2'b10, 1'b1, 17'h1FFFF, 5'd3},
      {2'b10, 1'b1, 17'h0A123, 5'd5},
      {2'b10, 1'b1, 17'h0BFFF, 5'd30}
   };

   // independent model from the requirements: returns {y2, y1, x}
   function automatic logic [6:0] model(input logic [1:0] m, input logic nx,
                                        input logic [16:0] c, input logic [4:0] n);
      logic [3:0]  low4;
      logic [4:0]  t;
      logic [16:0] c2;
      logic [4:0]  r;
      begin
         if (m == 2'b01) begin
            low4 = {c[4], c[3], c[2], c[0]} - c[15:12];
            t    = c[4] ? 5'd24 : 5'd8;
            r    = 5'({1'b0, low4}) + c[16:12] + t;
            model = {c[1], c[1], r};
         end else if (m == 2'b10) begin
            c2 = nx ? c + 17'd1 : c;
            r  = c2[16:12] + n;
            model = {1'b1, 1'b1, r};
         end else begin
            r  = c[16:12] + n;
            model = {1'b0, 1'b0, r};
         end
      end
   endfunction

   function automatic string req_of(input logic [1:0] m, input logic nx);
      if (m == 2'b01) return "R4/R5";
      if (m == 2'b10) return nx ? "R7" : "R6";
      if (m == 2'b11) return "R9";
      return "R3";
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // drive one strobe; returns at the negedge after the capturing edge
   task automatic apply(input logic [1:0] m, input logic nx,
                        input logic [16:0] c, input logic [4:0] n);
      @(negedge clk_i);
      mode = m; next_slot = nx; native_clk = c; resp_cnt = n;
      strobe = 1'b1;
      @(negedge clk_i);
      strobe = 1'b0;
   endtask

   task automatic check_result(input string req, input logic [6:0] exp);
      check(req, {25'd0, y2_out, y1_out, x_out}, {25'd0, exp});
      check("R2", {31'd0, out_valid}, 32'd1);
   endtask

   logic [6:0] ref_a;
   logic [6:0] ref_b;

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk_i);
      check("R1", {25'd0, out_valid, y2_out, y1_out, x_out}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk_i);
      check("R1", {25'd0, out_valid, y2_out, y1_out, x_out}, 32'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][24:23], VEC[i][22], VEC[i][21:5], VEC[i][4:0]);
         check_result(req_of(VEC[i][24:23], VEC[i][22]),
                      model(VEC[i][24:23], VEC[i][22], VEC[i][21:5], VEC[i][4:0]));
      end

      // R2: no strobe -> valid drops, outputs hold while inputs change
      ref_a = {y2_out, y1_out, x_out};
      mode = 2'b01; native_clk = 17'h1234F; resp_cnt = 5'd13;
      @(negedge clk_i);
      check("R2", {31'd0, out_valid}, 32'd0);
      check("R2", {25'd0, y2_out, y1_out, x_out}, {25'd0, ref_a});

      // R7: wrap of all-ones clock, and carry from the low twelve bits
      apply(2'b10, 1'b1, 17'h1FFFF, 5'd3);
      check_result("R7", 7'b11_00011);
      apply(2'b10, 1'b1, 17'h00FFF, 5'd0);
      check_result("R7", 7'b11_00001);

      // R4: modulo-16 wrap in first step, clock bit 4 clear (offset 8)
      // c=0x1F000: low4=0, hi=31 -> (0-15)&15=1, +31=32->0, +8 = 8
      apply(2'b01, 1'b0, 17'h1F000, 5'd0);
      check_result("R4", 7'b00_01000);
      // c=0x00010: low4=8, hi=0 -> 8+0+24 = 32 -> 0, bit1 clear
      apply(2'b01, 1'b0, 17'h00010, 5'd0);
      check_result("R4", 7'b00_00000);
      // R5: bit1 set -> y1=y2=1; c=0x00002: low4=0, +8 = 8
      apply(2'b01, 1'b0, 17'h00002, 5'd0);
      check_result("R5", 7'b11_01000);

      // R8: next_slot ignored in scan, inquiry and spare modes
      apply(2'b00, 1'b1, 17'h1FFFF, 5'd2);
      check_result("R8", model(2'b00, 1'b0, 17'h1FFFF, 5'd2));
      apply(2'b01, 1'b1, 17'h0BFFF, 5'd0);
      check_result("R8", model(2'b01, 1'b0, 17'h0BFFF, 5'd0));
      apply(2'b11, 1'b1, 17'h07FFF, 5'd1);
      check_result("R8", model(2'b00, 1'b0, 17'h07FFF, 5'd1));

      // R10: counter ignored in inquiry mode
      apply(2'b01, 1'b0, 17'h0D0A5, 5'd0);
      ref_b = {y2_out, y1_out, x_out};
      apply(2'b01, 1'b0, 17'h0D0A5, 5'd31);
      check("R10", {25'd0, y2_out, y1_out, x_out}, {25'd0, ref_b});

      // R9: spare code equals scan for the same inputs
      apply(2'b11, 1'b0, 17'h1C3F0, 5'd22);
      check_result("R9", model(2'b00, 1'b0, 17'h1C3F0, 5'd22));

      // R1: reset in mid-run clears outputs again
      @(negedge clk_i);
      rst_n = 1'b0;
      @(negedge clk_i);
      check("R1", {25'd0, out_valid, y2_out, y1_out, x_out}, 32'd0);
      rst_n = 1'b1;

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule